// File: doc/BRIEF.md
# 18-bit LVDS Pixel Lane Packer

This block feeds a seven-to-one serial flat-panel link. Once per pixel clock it takes one 18-bit colour pixel (6 bits each of red, green and blue) together with horizontal sync, vertical sync and a data-enable flag. It spreads these 21 bits over three 7-bit data lanes and presents each lane word in parallel. Green and blue cross lane boundaries, and the sync and enable bits sit in the top of the third lane.

A second clock running at seven times the pixel rate drives four shift registers. Three of them carry the data lanes and the fourth produces a clock-lane pattern that frames each 7-bit word. A phase counter in the fast domain raises an internal load strobe once every seven fast cycles. The strobe copies the parallel words into the shifters. The differential line drivers and the multiplying PLL sit outside this block, and the two clocks are assumed phase-related.

Top module: `lvds_lane_packer`

## Requirements
- R1: While reset is asserted, and after release until the first load, all lane words, all serial data lanes and the clock lane are 0.
- R2: Lane 0 word bits [5:0] equal red[5:0] and bit [6] equals green[0].
- R3: Lane 1 word bits [4:0] equal green[5:1] and bits [6:5] equal blue[1:0].
- R4: Lane 2 word bits [3:0] equal blue[5:2], bit [4] is hsync, bit [5] is vsync and bit [6] is data enable.
- R5: Pixel inputs are captured only on the falling edge of the pixel clock. The lane words keep their value when inputs change between falling edges.
- R6: The load strobe fires once every 7 fast-clock rising edges. The first one is the 7th rising edge after reset release. Serial slot s (0..6) of frame f is visible after rising edge 7+7f+s.
- R7: With MSB_FIRST=1, slot s carries word bit 6-s, so the first-listed bit goes last. With MSB_FIRST=0, slot s carries word bit s.
- R8: The clock lane emits 1,1,0,0,0,1,1 in slots 0..6 of every frame, in step with the data frames.
- R9: Each serial frame carries the lane words that are present at its load edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| pix_clk_i | input | 1 | Pixel clock; inputs are captured on its falling edge |
| fast_clk_i | input | 1 | Bit clock at seven times the pixel rate |
| red_i | input | 6 | Red channel, bit 5 is MSB |
| green_i | input | 6 | Green channel, bit 5 is MSB |
| blue_i | input | 6 | Blue channel, bit 5 is MSB |
| hsync_i | input | 1 | Horizontal sync |
| vsync_i | input | 1 | Vertical sync |
| de_i | input | 1 | Data enable |
| lane_words_o | output | 21 | Parallel lane words, lane n at bits [7n+6:7n] |
| lane_ser_o | output | 3 | Serial data lanes, bit n is lane n |
| clk_ser_o | output | 1 | Serial clock lane |

## Verification
All-zero and all-one pixels confirm that every lane carries its full width. A single one walked across all 21 input bits tells apart every pair of lane bit positions, so any swap in the mapping or in the shift order shows up as a wrong lane or slot. Seeded random pixels with random sync and enable mix the lanes. Changing inputs half a pixel clock before the capture edge separates falling-edge capture from rising-edge capture. The serial stream is rebuilt slot by slot and compared against the word expected at each load, and the clock-lane pattern is checked in the same slots.

// File: rtl/lvds_pack_pkg.sv
`timescale 1ns/1ps
package lvds_pack_pkg;
  localparam int COLOR_W = 6;
  localparam int LANE_W  = 7;
  localparam int N_LANES = 3;
  localparam int WORDS_W = N_LANES * LANE_W;
  localparam logic [LANE_W-1:0] CLK_PATTERN = 7'b1100011;

  typedef struct packed {
    logic               de;
    logic               vsync;
    logic               hsync;
    logic [COLOR_W-1:0] blue;
    logic [COLOR_W-1:0] green;
    logic [COLOR_W-1:0] red;
  } pixel_t;

  function automatic logic [WORDS_W-1:0] pack_lanes(pixel_t p);
    logic [LANE_W-1:0] w0, w1, w2;
    w0 = {p.green[0], p.red};
    w1 = {p.blue[1:0], p.green[5:1]};
    w2 = {p.de, p.vsync, p.hsync, p.blue[5:2]};
    return {w2, w1, w0};
  endfunction
endpackage

// File: rtl/pixel_capture.sv
`timescale 1ns/1ps
module pixel_capture
  import lvds_pack_pkg::*;
(
  input  logic               pix_clk_i,
  input  logic               rst_ni,
  input  pixel_t             pix_i,
  output logic [WORDS_W-1:0] words_o
);
  pixel_t pix_q;

  // falling-edge capture
  always_ff @(negedge pix_clk_i or negedge rst_ni) begin
    if (!rst_ni) pix_q <= '0;
    else         pix_q <= pix_i;
  end

  assign words_o = pack_lanes(pix_q);
endmodule

// File: rtl/phase_gen.sv
`timescale 1ns/1ps
module phase_gen #(
  parameter int PERIOD = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic load_o
);
  localparam int CNT_W = $clog2(PERIOD);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else                      phase_q <= phase_q + 1'b1;
  end

  assign load_o = (phase_q == LAST);
endmodule

// File: rtl/lane_serializer.sv
`timescale 1ns/1ps
module lane_serializer #(
  parameter int W         = 7,
  parameter bit MSB_FIRST = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  output logic         ser_o
);
  logic [W-1:0] sh_q;

  generate
    if (MSB_FIRST) begin : g_msb
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     sh_q <= '0;
        else if (load_i) sh_q <= word_i;
        else             sh_q <= {sh_q[W-2:0], 1'b0};
      end
      assign ser_o = sh_q[W-1];
    end else begin : g_lsb
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     sh_q <= '0;
        else if (load_i) sh_q <= word_i;
        else             sh_q <= {1'b0, sh_q[W-1:1]};
      end
      assign ser_o = sh_q[0];
    end
  endgenerate
endmodule

// File: rtl/lvds_lane_packer.sv
`timescale 1ns/1ps
module lvds_lane_packer
  import lvds_pack_pkg::*;
#(
  parameter bit MSB_FIRST = 1'b1
) (
  input  logic               rst_ni,
  input  logic               pix_clk_i,
  input  logic               fast_clk_i,
  input  logic [COLOR_W-1:0] red_i,
  input  logic [COLOR_W-1:0] green_i,
  input  logic [COLOR_W-1:0] blue_i,
  input  logic               hsync_i,
  input  logic               vsync_i,
  input  logic               de_i,
  output logic [WORDS_W-1:0] lane_words_o,
  output logic [N_LANES-1:0] lane_ser_o,
  output logic               clk_ser_o
);
  pixel_t pix_in;
  logic   load_w;

  assign pix_in = '{de: de_i, vsync: vsync_i, hsync: hsync_i,
                    blue: blue_i, green: green_i, red: red_i};

  pixel_capture u_cap (
    .pix_clk_i (pix_clk_i),
    .rst_ni    (rst_ni),
    .pix_i     (pix_in),
    .words_o   (lane_words_o)
  );

  phase_gen #(.PERIOD(LANE_W)) u_phase (
    .clk_i  (fast_clk_i),
    .rst_ni (rst_ni),
    .load_o (load_w)
  );

  generate
    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
      lane_serializer #(.W(LANE_W), .MSB_FIRST(MSB_FIRST)) u_ser (
        .clk_i  (fast_clk_i),
        .rst_ni (rst_ni),
        .load_i (load_w),
        .word_i (lane_words_o[g*LANE_W +: LANE_W]),
        .ser_o  (lane_ser_o[g])
      );
    end
  endgenerate

  // pattern is a palindrome, so shift order does not matter
  lane_serializer #(.W(LANE_W), .MSB_FIRST(MSB_FIRST)) u_clk_ser (
    .clk_i  (fast_clk_i),
    .rst_ni (rst_ni),
    .load_i (load_w),
    .word_i (CLK_PATTERN),
    .ser_o  (clk_ser_o)
  );
endmodule

// File: rtl/lvds_lane_packer_checker.sv
`timescale 1ns/1ps
module lvds_lane_packer_checker
  import lvds_pack_pkg::*;
#(
  parameter bit MSB_FIRST = 1'b1
) (
  input logic               rst_ni,
  input logic               pix_clk_i,
  input logic               fast_clk_i,
  input logic [COLOR_W-1:0] red_i,
  input logic [COLOR_W-1:0] green_i,
  input logic [COLOR_W-1:0] blue_i,
  input logic               hsync_i,
  input logic               vsync_i,
  input logic               de_i,
  input logic [WORDS_W-1:0] lane_words_i,
  input logic [N_LANES-1:0] lane_ser_i,
  input logic               clk_ser_i,
  input logic               load_i
);
  logic       seen_q;
  logic       started_q;
  logic [2:0] slot_q;

  always_ff @(negedge pix_clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  always_ff @(posedge fast_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      slot_q    <= '0;
    end else if (load_i) begin
      started_q <= 1'b1;
      slot_q    <= '0;
    end else begin
      slot_q    <= slot_q + 1'b1;
    end
  end

  assert_lane0_map_R2: assert property (@(negedge pix_clk_i) disable iff (!rst_ni)
    seen_q |-> lane_words_i[6:0] == {$past(green_i[0]), $past(red_i)});
  assert_lane1_map_R3: assert property (@(negedge pix_clk_i) disable iff (!rst_ni)
    seen_q |-> lane_words_i[13:7] == {$past(blue_i[1:0]), $past(green_i[5:1])});
  assert_lane2_map_R4: assert property (@(negedge pix_clk_i) disable iff (!rst_ni)
    seen_q |-> lane_words_i[20:14] == {$past(de_i), $past(vsync_i), $past(hsync_i), $past(blue_i[5:2])});
  assert_idle_before_load_R1: assert property (@(posedge fast_clk_i) disable iff (!rst_ni)
    !started_q |-> (lane_ser_i == '0 && !clk_ser_i));
  assert_load_period_R6: assert property (@(posedge fast_clk_i) disable iff (!rst_ni)
    (started_q && load_i) |-> slot_q == 3'd6);
  assert_clk_low_R8: assert property (@(posedge fast_clk_i) disable iff (!rst_ni)
    (started_q && slot_q >= 3'd2 && slot_q <= 3'd4) |-> !clk_ser_i);
  assert_clk_high_R8: assert property (@(posedge fast_clk_i) disable iff (!rst_ni)
    (started_q && (slot_q <= 3'd1 || slot_q >= 3'd5)) |-> clk_ser_i);
  assert_first_bit_R7: assert property (@(posedge fast_clk_i) disable iff (!rst_ni)
    load_i |=> lane_ser_i[0] == (MSB_FIRST ? $past(lane_words_i[6]) : $past(lane_words_i[0])));
endmodule

bind lvds_lane_packer lvds_lane_packer_checker #(.MSB_FIRST(MSB_FIRST)) u_chk (
  .rst_ni       (rst_ni),
  .pix_clk_i    (pix_clk_i),
  .fast_clk_i   (fast_clk_i),
  .red_i        (red_i),
  .green_i      (green_i),
  .blue_i       (blue_i),
  .hsync_i      (hsync_i),
  .vsync_i      (vsync_i),
  .de_i         (de_i),
  .lane_words_i (lane_words_o),
  .lane_ser_i   (lane_ser_o),
  .clk_ser_i    (clk_ser_o),
  .load_i       (load_w)
);

// File: tb/lvds_lane_packer_bench.sv
`timescale 1ns/1ps
module lvds_lane_packer_bench;
  localparam bit MSB_FIRST = 1'b1;
  localparam logic [6:0] CLKP = 7'b1100011;

  logic        rst_ni = 1'b0;
  logic        pclk = 1'b0;
  logic        fclk = 1'b0;
  logic [5:0]  red = '0, green = '0, blue = '0;
  logic        hs = 1'b0, vs = 1'b0, de = 1'b0;
  logic [20:0] words;
  logic [2:0]  ser;
  logic        cser;

  int checks = 0;
  int errors = 0;
  int ecnt = 0;
  int slot;
  bit mon_en = 1'b0;
  bit done = 1'b0;
  logic [20:0] cur_pix = '0;   // {de,vs,hs,blue,green,red}
  logic [20:0] prev_pix = '0;
  logic [20:0] exp_w = '0;

  lvds_lane_packer #(.MSB_FIRST(MSB_FIRST)) u_lvds_lane_packer (
    .rst_ni (rst_ni), .pix_clk_i (pclk), .fast_clk_i (fclk),
    .red_i (red), .green_i (green), .blue_i (blue),
    .hsync_i (hs), .vsync_i (vs), .de_i (de),
    .lane_words_o (words), .lane_ser_o (ser), .clk_ser_o (cser)
  );

  always #5  fclk = ~fclk;
  always #35 pclk = ~pclk;

  function automatic logic [20:0] pack(logic [20:0] p);
    logic [5:0] r, g, b;
    logic [6:0] l0, l1, l2;
    r = p[5:0]; g = p[11:6]; b = p[17:12];
    l0 = {g[0], r[5], r[4], r[3], r[2], r[1], r[0]};
    l1 = {b[1], b[0], g[5], g[4], g[3], g[2], g[1]};
    l2 = {p[20], p[19], p[18], b[5], b[4], b[3], b[2]};
    return {l2, l1, l0};
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge fclk or negedge rst_ni)
    if (!rst_ni) ecnt <= 0;
    else         ecnt <= ecnt + 1;

  always @(negedge fclk) begin
    if (mon_en) begin
      if (ecnt < 7) begin
        chk(ser == 3'b000 && cser == 1'b0, "R1 idle serial", {28'd0, cser, ser}, 32'd0);
      end else begin
        slot = (ecnt - 7) % 7;
        if (slot == 0) exp_w = pack(cur_pix);   // R6 R9 frame word at load
        for (int l = 0; l < 3; l++) begin
          logic eb;
          eb = MSB_FIRST ? exp_w[l*7 + 6 - slot] : exp_w[l*7 + slot];
          chk(ser[l] == eb, "R7 R9 lane serial bit", {31'd0, ser[l]}, {31'd0, eb});
        end
        chk(cser == CLKP[6-slot], "R8 clock lane", {31'd0, cser}, {31'd0, CLKP[6-slot]});
      end
    end
  end

  task automatic drive(logic [20:0] p);
    @(posedge pclk);
    {de, vs, hs, blue, green, red} = p;
    cur_pix = p;
    #1 chk(words == pack(prev_pix), "R5 hold until falling edge", {11'd0, words}, {11'd0, pack(prev_pix)});
    @(negedge pclk);
    #1;
    chk(words[6:0]   == pack(p)[6:0],   "R2 lane0", {25'd0, words[6:0]},   {25'd0, pack(p)[6:0]});
    chk(words[13:7]  == pack(p)[13:7],  "R3 lane1", {25'd0, words[13:7]},  {25'd0, pack(p)[13:7]});
    chk(words[20:14] == pack(p)[20:14], "R4 lane2", {25'd0, words[20:14]}, {25'd0, pack(p)[20:14]});
    prev_pix = p;
  endtask

  initial begin
    void'($urandom(32'h5eed));
    #50;
    chk(words == '0 && ser == '0 && cser == 1'b0, "R1 reset state", {10'd0, cser, words}, 32'd0);
    #52 rst_ni = 1'b1;
    #1;
    chk(words == '0, "R1 after release", {11'd0, words}, 32'd0);
    mon_en = 1'b1;
    drive(21'h000000);
    drive(21'h1fffff);
    for (int i = 0; i < 21; i++) drive(21'd1 << i);
    drive(21'h000000);
    for (int i = 0; i < 21; i++) drive(~(21'd1 << i));
    for (int i = 0; i < 250; i++) drive(21'($urandom()));
    drive(21'h000000);
    @(posedge pclk);
    @(negedge fclk);
    mon_en = 1'b0;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule